// File: doc/BRIEF.md
# Interrupt-Return Bus Snooper

This block sits beside an interrupting peripheral on an 8-bit processor bus and watches it without ever driving it. It keeps the peripheral's interrupt request and in-service state and takes part in a priority daisy chain. An interrupt-acknowledge cycle moves a pending request into service. The block then watches consecutive opcode fetches for the two-byte return-from-interrupt sequence, a prefix byte `0xED` followed directly by `0x4D`. When it sees that sequence while it is the highest-priority device in service, it retires the in-service state and releases the chain for lower devices.

All bus strobes are active low and are sampled on the system clock. A byte counts as an opcode fetch on the clock where the read strobe rises while the fetch strobe and the memory strobe are both low. The peripheral raises a request with a one-cycle pulse on `raise_req`.

Top module: `irq_return_snooper`

## Requirements
- R1: After the synchronous active-low reset, nothing is pending, `in_service` is 0, `irq_n` is 1, and `chain_en_out` follows `chain_en_in`.
- R2: A byte is taken into the matcher only on a clock where `rd_n` is 1 after having been 0 on the previous clock while `fetch_n` and `memrq_n` are both 0. Each such rise counts once. A memory read with `fetch_n` high does not disturb the matcher.
- R3: A fetch of `0x4D` that directly follows a fetch of `0xED` while `in_service` is 1 and `chain_en_in` is 1 clears `in_service` at that clock edge.
- R4: Any other fetched byte between the prefix and `0x4D` disarms the matcher. A repeated `0xED` keeps it armed.
- R5: The sequence `0xED 0x45` never clears `in_service`.
- R6: `0x4D` without a preceding prefix fetch, and `0xED` on its own, never clear `in_service`.
- R7: On the first clock where `fetch_n` and `io_req_n` are both 0, a pending request with `chain_en_in` = 1 and `in_service` = 0 moves into service: `in_service` becomes 1 and the pending request clears.
- R8: An acknowledge while `chain_en_in` is 0 leaves the request pending and `in_service` at 0.
- R9: A detected return while `chain_en_in` is 0 leaves `in_service` set.
- R10: `chain_en_out` is 1 exactly when `chain_en_in` is 1, nothing is pending and the block is not in service.
- R11: `irq_n` is 0 exactly when a request is pending, the block is not in service and `chain_en_in` is 1.
- R12: `raise_req` sets the pending request even on the clock where a return retires service or an acknowledge grants it. In both cases the request remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 8 | Processor data bus, observed only |
| fetch_n | input | 1 | Opcode-fetch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| memrq_n | input | 1 | Memory request strobe, active low |
| io_req_n | input | 1 | I/O request strobe, active low |
| raise_req | input | 1 | One-cycle request pulse from the peripheral |
| chain_en_in | input | 1 | Priority chain enable from the higher device |
| chain_en_out | output | 1 | Priority chain enable to the lower device |
| irq_n | output | 1 | Interrupt request, active low |
| in_service | output | 1 | The block's interrupt is being serviced |

## Verification
Two functions can act on the same clock edge. A new peripheral request can arrive on the edge where a detected return retires service, and it can also arrive on the edge where an acknowledge grants service. The bench pulses `raise_req` on the exact clock where the read strobe of the `0x4D` fetch rises, and again on the first clock of an acknowledge. Its behavioural model, compared on every clock, expects `in_service` to change and the request to remain pending in both cases. That pending request shows at the ports through `irq_n` and `chain_en_out`.

// File: rtl/irq_return_snooper_pkg.sv
// Package: shared constants and types of the interrupt-return snooper.
// Assumes an 8-bit bus and a two-byte return sequence (prefix, code).
package irq_return_snooper_pkg;
    localparam int BUS_W = 8;
    localparam logic [BUS_W-1:0] PREFIX_CODE = 8'hED;
    localparam logic [BUS_W-1:0] RETURN_CODE = 8'h4D;

    typedef enum logic {
        MATCH_IDLE  = 1'b0,
        MATCH_ARMED = 1'b1
    } match_state_e;
endpackage

// File: rtl/bus_fetch_tap.sv
// Module: bus_fetch_tap
// Turns the raw bus strobes into single-cycle events: one per opcode fetch
// (read strobe rising during a memory fetch) and one per acknowledge start
// (fetch strobe together with I/O request). Assumes strobes are already
// synchronous to clk and held for at least one clock.
module bus_fetch_tap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fetch_n,
    input  logic              rd_n,
    input  logic              memrq_n,
    input  logic              io_req_n,
    output logic              fetch_evt,
    output logic [DATA_W-1:0] fetch_byte,
    output logic              ack_evt
);
    logic rd_q;
    logic ack_q;
    logic ack_lvl;

    // Remember the previous read strobe and acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b1;
            ack_q <= 1'b0;
        end else begin
            rd_q  <= rd_n;
            ack_q <= ack_lvl;
        end
    end

    // Decode the fetch and acknowledge events from current and previous strobes.
    always_comb begin
        ack_lvl    = !fetch_n && !io_req_n;
        ack_evt    = ack_lvl && !ack_q;
        fetch_evt  = !rd_q && rd_n && !fetch_n && !memrq_n;
        fetch_byte = bus_data;
    end

    // R2
    one_fetch_per_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_evt |=> !fetch_evt);
endmodule

// File: rtl/return_matcher.sv
// Module: return_matcher
// Two-state matcher over consecutive opcode fetches. A fetch of the prefix
// arms it; the next fetch either completes the return (code byte) or
// re-arms/disarms it. Assumes fetch_evt is a single-cycle pulse.
module return_matcher
    import irq_return_snooper_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] PFX  = 8'hED,
    parameter logic [DATA_W-1:0] RET  = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_evt,
    input  logic [DATA_W-1:0] fetch_byte,
    output logic              ret_hit
);
    match_state_e state_q;
    match_state_e state_d;

    // Compute the match pulse and the next matcher state.
    always_comb begin
        ret_hit = fetch_evt && (state_q == MATCH_ARMED) && (fetch_byte == RET);
        state_d = state_q;
        if (fetch_evt) begin
            state_d = (fetch_byte == PFX) ? MATCH_ARMED : MATCH_IDLE;
        end
    end

    // Hold the matcher state between fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MATCH_IDLE;
        else        state_q <= state_d;
    end

    // R4
    match_consumes_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit |=> (state_q == MATCH_IDLE));
endmodule

// File: rtl/service_ctrl.sv
// Module: service_ctrl
// Holds the pending request and in-service flags. Grants service on an
// acknowledge when enabled by the chain; retires it on a detected return
// when this device is the highest in service. Assumes single-cycle events.
module service_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_req,
    input  logic ack_evt,
    input  logic ret_hit,
    input  logic chain_en_in,
    output logic pend,
    output logic in_service
);
    logic grant;
    logic retire;

    // Decide grant and retire conditions for this clock.
    always_comb begin
        grant  = ack_evt && pend && !in_service && chain_en_in;
        retire = ret_hit && in_service && chain_en_in;
    end

    // Update the pending and in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            in_service <= 1'b0;
        end else begin
            if (raise_req)  pend <= 1'b1;
            else if (grant) pend <= 1'b0;
            if (grant)       in_service <= 1'b1;
            else if (retire) in_service <= 1'b0;
        end
    end

    // R7
    ack_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_evt && pend && !in_service && chain_en_in) |=> in_service);
    // R3
    return_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && in_service && chain_en_in) |=> !in_service);
    // R9
    blocked_return_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && in_service && !chain_en_in) |=> in_service);
endmodule

// File: rtl/irq_return_snooper.sv
// Module: irq_return_snooper (top)
// Passive bus watcher for one interrupting peripheral: detects acknowledge
// and the two-byte return sequence and drives the chain and request lines.
// Assumes synchronous, active-low bus strobes and a single clock domain.
module irq_return_snooper #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] PFX_CODE = 8'hED,
    parameter logic [DATA_W-1:0] RET_CODE = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fetch_n,
    input  logic              rd_n,
    input  logic              memrq_n,
    input  logic              io_req_n,
    input  logic              raise_req,
    input  logic              chain_en_in,
    output logic              chain_en_out,
    output logic              irq_n,
    output logic              in_service
);
    logic              fetch_evt;
    logic [DATA_W-1:0] fetch_byte;
    logic              ack_evt;
    logic              ret_hit;
    logic              pend;

    bus_fetch_tap #(.DATA_W(DATA_W)) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_data   (bus_data),
        .fetch_n    (fetch_n),
        .rd_n       (rd_n),
        .memrq_n    (memrq_n),
        .io_req_n   (io_req_n),
        .fetch_evt  (fetch_evt),
        .fetch_byte (fetch_byte),
        .ack_evt    (ack_evt)
    );

    return_matcher #(.DATA_W(DATA_W), .PFX(PFX_CODE), .RET(RET_CODE)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_evt  (fetch_evt),
        .fetch_byte (fetch_byte),
        .ret_hit    (ret_hit)
    );

    service_ctrl u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_req   (raise_req),
        .ack_evt     (ack_evt),
        .ret_hit     (ret_hit),
        .chain_en_in (chain_en_in),
        .pend        (pend),
        .in_service  (in_service)
    );

    // Drive the chain enable and request line from the held flags.
    always_comb begin
        chain_en_out = chain_en_in && !pend && !in_service;
        irq_n        = !(pend && !in_service && chain_en_in);
    end

    // R10
    chain_blocked_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !chain_en_out);
endmodule

// File: tb/irq_return_snooper_tb.sv
`timescale 1ns/1ps
module irq_return_snooper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       fetch_n = 1'b1, rd_n = 1'b1, memrq_n = 1'b1, io_req_n = 1'b1;
    logic       raise_req = 1'b0, chain_en_in = 1'b1;
    logic       chain_en_out, irq_n, in_service;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // behavioural reference state
    bit m_pend = 0, m_ins = 0, m_arm = 0, m_rd_prev = 1, m_ack_prev = 0;

    always #2.5 clk = ~clk;

    irq_return_snooper u_dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .fetch_n(fetch_n),
        .rd_n(rd_n), .memrq_n(memrq_n), .io_req_n(io_req_n),
        .raise_req(raise_req), .chain_en_in(chain_en_in),
        .chain_en_out(chain_en_out), .irq_n(irq_n), .in_service(in_service)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit fe, ae, ret, grant, ack_lvl;
        if (!rst_n) begin
            m_pend = 0; m_ins = 0; m_arm = 0; m_rd_prev = 1; m_ack_prev = 0;
            return;
        end
        ack_lvl = !fetch_n && !io_req_n;
        fe    = !m_rd_prev && rd_n && !fetch_n && !memrq_n;
        ae    = ack_lvl && !m_ack_prev;
        ret   = fe && m_arm && (bus_data == 8'h4D);
        grant = ae && m_pend && !m_ins && chain_en_in;
        if (fe) m_arm = (bus_data == 8'hED);
        if (grant) m_ins = 1;
        else if (ret && m_ins && chain_en_in) m_ins = 0;
        if (raise_req) m_pend = 1;
        else if (grant) m_pend = 0;
        m_rd_prev = rd_n;
        m_ack_prev = ack_lvl;
    endtask

    // one clock: model follows the edge, outputs compared just after it
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        chk(cur_tag, in_service, m_ins, "in_service");
        chk(cur_tag, irq_n, !(m_pend && !m_ins && chain_en_in), "irq_n");
        chk(cur_tag, chain_en_out, chain_en_in && !m_pend && !m_ins, "chain_en_out");
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] b, input bit is_fetch, input bit raise_mid);
        bus_data = b; memrq_n = 0; rd_n = 0; fetch_n = !is_fetch;
        tick();
        rd_n = 1; raise_req = raise_mid;
        tick();
        raise_req = 0; memrq_n = 1; fetch_n = 1;
        tick();
    endtask

    task automatic ack(input bit raise_mid);
        fetch_n = 0; io_req_n = 0; raise_req = raise_mid;
        tick();
        raise_req = 0;
        tick();
        fetch_n = 1; io_req_n = 1;
        tick();
    endtask

    task automatic raise();
        raise_req = 1; tick(); raise_req = 0; tick();
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        tick();
        // R1: reset state
        chk("R1", in_service, 1'b0, "in_service after reset");
        chk("R1", irq_n, 1'b1, "irq_n after reset");
        chk("R1", chain_en_out, 1'b1, "chain_en_out after reset");

        cur_tag = "R11"; raise();
        chk("R11", irq_n, 1'b0, "irq_n with pending");
        chk("R10", chain_en_out, 1'b0, "chain blocked by pending");

        cur_tag = "R8"; chain_en_in = 0; tick(); ack(0);
        chk("R8", in_service, 1'b0, "ack ignored while disabled");
        chain_en_in = 1; tick();
        chk("R8", irq_n, 1'b0, "request still pending");

        cur_tag = "R7"; ack(0);
        chk("R7", in_service, 1'b1, "ack grants service");
        chk("R7", irq_n, 1'b1, "pending cleared by grant");

        cur_tag = "R5"; bus_read(8'hED, 1, 0); bus_read(8'h45, 1, 0);
        chk("R5", in_service, 1'b1, "ED 45 is not a return");
        cur_tag = "R6"; bus_read(8'h4D, 1, 0);
        chk("R6", in_service, 1'b1, "lone 4D");
        bus_read(8'hED, 1, 0); bus_read(8'h00, 1, 0);
        chk("R6", in_service, 1'b1, "lone ED");
        cur_tag = "R4"; bus_read(8'h4D, 1, 0);
        chk("R4", in_service, 1'b1, "ED 00 4D not a return");

        cur_tag = "R2"; bus_read(8'hED, 1, 0); bus_read(8'h4D, 0, 0);
        chk("R2", in_service, 1'b1, "plain memory read not a fetch");
        bus_read(8'h4D, 1, 0);
        chk("R2", in_service, 1'b0, "matcher kept across plain read");
        chk("R3", chain_en_out, 1'b1, "chain released after return");

        cur_tag = "R9"; raise(); ack(0);
        chk("R9", in_service, 1'b1, "re-granted");
        chain_en_in = 0; tick();
        bus_read(8'hED, 1, 0); bus_read(8'h4D, 1, 0);
        chk("R9", in_service, 1'b1, "return ignored while disabled");
        chain_en_in = 1; tick();
        cur_tag = "R3"; bus_read(8'hED, 1, 0); bus_read(8'h4D, 1, 0);
        chk("R3", in_service, 1'b0, "ED 4D retires");

        cur_tag = "R12"; raise(); ack(0);
        bus_read(8'hED, 1, 0); bus_read(8'h4D, 1, 1);
        chk("R12", in_service, 1'b0, "retired on collision edge");
        chk("R12", irq_n, 1'b0, "new request pending after collision");
        ack(1);
        chk("R12", in_service, 1'b1, "granted with raise on same edge");
        chk("R12", chain_en_out, 1'b0, "chain blocked");

        cur_tag = "R4"; bus_read(8'hED, 1, 0); bus_read(8'hED, 1, 0); bus_read(8'h4D, 1, 0);
        chk("R4", in_service, 1'b0, "ED ED 4D retires");
        chk("R11", irq_n, 1'b0, "request from acknowledge edge still pending");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule